// File: doc/BRIEF.md
# Triggered Circular Capture Controller

This block steers the writing of decimated two-channel sample data into a circular sample buffer. When software arms it, every sample-valid strobe from the decimator writes one entry at the current write pointer and then advances the pointer. The pointer wraps at the buffer depth, which is 16384 entries by default. Armed capture runs without a stop until a trigger pulse arrives from the trigger selector.

The first trigger accepted after arming copies the write pointer into a trigger-pointer register and sets a sticky triggered flag. From then on the controller counts a programmed number of further writes. When that count is used up, writing stops and a done flag rises. Software can then read the buffer around the trigger pointer. It can re-arm to continue from where the pointer stopped, or it can issue a reset command that returns the pointer to zero.

Commands arrive as single-cycle pulses on plain register ports. The block drives the buffer's write address, write enable and write data. The sample memory itself sits outside this block.

Top module: `capture_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `cur_ptr` and `trig_ptr` are 0, `triggered` and `done` are 0, and `wr_en` is 0.
- R2: `wr_en` is 1 only in a cycle where the controller is armed or counting post-trigger samples, `smp_valid` is 1 and `cmd_reset` is 0. `wr_addr` always equals `cur_ptr`.
- R3: Each write advances `cur_ptr` by one on the next clock edge, and the pointer wraps from 16383 to 0. Without a write the pointer holds.
- R4: `trig_in` has no effect (the flags and `trig_ptr` stay unchanged) when the controller is idle, when it is already counting after a trigger, and when capture is done.
- R5: A trigger accepted while armed loads `trig_ptr` with the `cur_ptr` value of that cycle and sets `triggered` on the next edge. `triggered` then stays 1 until an arm or reset command, and `trig_ptr` does not change while it is 1.
- R6: After an accepted trigger, exactly `delay_cfg` further writes happen in later cycles. A write that occurs in the trigger cycle itself is not counted. After the last of these writes `done` becomes 1 and writing stops. With `delay_cfg` = 0, `done` becomes 1 on the edge after the trigger.
- R7: A `cmd_reset` pulse blocks any write in its cycle. On the next edge it sets `cur_ptr` and `trig_ptr` to 0 and clears `triggered` and `done`. It takes priority over `cmd_arm`, and the controller is left idle.
- R8: A `cmd_arm` pulse clears `triggered` and `done` and arms the controller. Re-arming after capture is done resumes writing from the current pointer, without returning it to 0.
- R9: `wr_data_a` and `wr_data_b` carry the low 14 bits of `smp_a` and `smp_b`. Bits 15:14 of the write data are always 0.
- R10: A trigger in the same cycle as `cmd_arm` is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_arm | input | 1 | Single-cycle arm command |
| cmd_reset | input | 1 | Single-cycle write-state reset command |
| smp_valid | input | 1 | Decimated sample strobe |
| trig_in | input | 1 | Trigger pulse from the trigger selector |
| delay_cfg | input | 32 | Number of post-trigger writes |
| smp_a | input | 16 | Channel A sample |
| smp_b | input | 16 | Channel B sample |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | 14 | Buffer write address |
| wr_data_a | output | 16 | Channel A write data |
| wr_data_b | output | 16 | Channel B write data |
| cur_ptr | output | 14 | Current write pointer |
| trig_ptr | output | 14 | Pointer latched at trigger |
| triggered | output | 1 | Sticky trigger-seen flag |
| done | output | 1 | Post-trigger capture finished |

## Verification
Some behaviour is checked by assertions on every cycle:
- writes are gated by the sample strobe, and no write happens after done;
- the pointer steps by one per write and wraps at the top;
- `trig_ptr` stays frozen while triggered;
- done implies triggered;
- a reset command clears the pointer and the flags.

Other behaviour can only be shown by the bench's scenarios:
- the exact count of post-trigger writes, including the zero-delay case;
- triggers being ignored when the controller is idle, already counting or done, and in an arm cycle;
- re-arming resuming at the old pointer;
- the full 16384-entry wrap.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [1:0] {
      CAP_IDLE  = 2'd0,
      CAP_ARMED = 2'd1,
      CAP_POST  = 2'd2,
      CAP_DONE  = 2'd3
   } cap_state_e;
endpackage

// File: rtl/cap_ptr.sv
module cap_ptr #(
   parameter int DEPTH = 16384,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic [ADDR_W-1:0] ptr
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
   localparam bit POW2 = ((1 << ADDR_W) == DEPTH);

   logic [ADDR_W-1:0] ptr_nxt;

   generate
      if (POW2) begin : g_wrap_natural
         always_comb ptr_nxt = ptr + 1'b1;
      end else begin : g_wrap_cmp
         always_comb ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (clr)  ptr <= '0;
      else if (inc)  ptr <= ptr_nxt;
   end

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && ptr == LAST) |=> ptr == '0); // R3
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(ptr)); // R3
endmodule

// File: rtl/cap_postcnt.sv
module cap_postcnt #(
   parameter int DLY_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   input  logic             dec,
   output logic             last,
   output logic             zero_in
);
   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   logic [DLY_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (dec && cnt != '0)  cnt <= cnt - ONE;
   end

   assign last    = (cnt == ONE);
   assign zero_in = (load_val == '0);
endmodule

// File: rtl/cap_pack.sv
module cap_pack #(
   parameter int IN_W  = 16,
   parameter int SMP_W = 14,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   generate
      if (SMP_W > IN_W || SMP_W > OUT_W) begin : g_bad
         $error("cap_pack: SMP_W exceeds IN_W or OUT_W");
      end
      if (OUT_W > SMP_W) begin : g_pad
         assign dout = {{(OUT_W - SMP_W){1'b0}}, din[SMP_W-1:0]};
      end else begin : g_exact
         assign dout = din[SMP_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
   import cap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_arm,
   input  logic       cmd_reset,
   input  logic       trig_acc,
   input  logic       dly_zero,
   input  logic       wr_en,
   input  logic       cnt_last,
   output cap_state_e state
);
   cap_state_e state_nxt;

   always_comb begin
      state_nxt = state;
      if (cmd_reset) begin
         state_nxt = CAP_IDLE;
      end else if (cmd_arm) begin
         state_nxt = CAP_ARMED;
      end else begin
         unique case (state)
            CAP_ARMED: if (trig_acc) state_nxt = dly_zero ? CAP_DONE : CAP_POST;
            CAP_POST:  if (wr_en && cnt_last) state_nxt = CAP_DONE;
            default:   state_nxt = state;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= CAP_IDLE;
      else        state <= state_nxt;
   end

   AST_ARM_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_arm && !cmd_reset) |=> state == CAP_ARMED); // R8
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
   import cap_pkg::*;
#(
   parameter int DEPTH = 16384,
   parameter int DLY_W = 32,
   parameter int IN_W  = 16,
   parameter int SMP_W = 14,
   parameter int OUT_W = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_arm,
   input  logic              cmd_reset,
   input  logic              smp_valid,
   input  logic              trig_in,
   input  logic [DLY_W-1:0]  delay_cfg,
   input  logic [IN_W-1:0]   smp_a,
   input  logic [IN_W-1:0]   smp_b,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [OUT_W-1:0]  wr_data_a,
   output logic [OUT_W-1:0]  wr_data_b,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic [ADDR_W-1:0] trig_ptr,
   output logic              triggered,
   output logic              done
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("capture_ctrl: DEPTH must be at least 2");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("capture_ctrl: DLY_W must be positive");
      end
   endgenerate

   cap_state_e state;
   logic       capturing;
   logic       trig_acc;
   logic       cnt_last;
   logic       dly_zero;

   assign capturing = (state == CAP_ARMED) || (state == CAP_POST);
   assign wr_en     = capturing && smp_valid && !cmd_reset;
   assign trig_acc  = (state == CAP_ARMED) && trig_in && !cmd_arm && !cmd_reset;
   assign wr_addr   = cur_ptr;
   assign triggered = (state == CAP_POST) || (state == CAP_DONE);
   assign done      = (state == CAP_DONE);

   cap_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_arm   (cmd_arm),
      .cmd_reset (cmd_reset),
      .trig_acc  (trig_acc),
      .dly_zero  (dly_zero),
      .wr_en     (wr_en),
      .cnt_last  (cnt_last),
      .state     (state)
   );

   cap_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cmd_reset),
      .inc   (wr_en),
      .ptr   (cur_ptr)
   );

   cap_postcnt #(.DLY_W(DLY_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cmd_reset),
      .load     (trig_acc),
      .load_val (delay_cfg),
      .dec      (wr_en && state == CAP_POST),
      .last     (cnt_last),
      .zero_in  (dly_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         trig_ptr <= '0;
      else if (cmd_reset) trig_ptr <= '0;
      else if (trig_acc)  trig_ptr <= cur_ptr;
   end

   cap_pack #(.IN_W(IN_W), .SMP_W(SMP_W), .OUT_W(OUT_W)) u_pack_a (
      .din (smp_a), .dout (wr_data_a)
   );
   cap_pack #(.IN_W(IN_W), .SMP_W(SMP_W), .OUT_W(OUT_W)) u_pack_b (
      .din (smp_b), .dout (wr_data_b)
   );

   AST_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (smp_valid && !cmd_reset)); // R2
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cur_ptr == ADDR_W'($past(cur_ptr) + 1'b1)); // R3
   AST_TRIG_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered && !cmd_reset) |=> $stable(trig_ptr)); // R5
   AST_DONE_IMPLIES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> triggered); // R5
   AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_en); // R6
   AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> (cur_ptr == '0 && trig_ptr == '0 && !triggered && !done)); // R7
   AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_arm |=> (!triggered && !done)); // R8
endmodule

// File: tb/sim_capture_ctrl.sv
module sim_capture_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16384;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_arm = 1'b0, cmd_reset = 1'b0, smp_valid = 1'b0, trig_in = 1'b0;
   logic [31:0] delay_cfg = '0;
   logic [15:0] smp_a = '0, smp_b = '0;
   logic        wr_en;
   logic [13:0] wr_addr, cur_ptr, trig_ptr;
   logic [15:0] wr_data_a, wr_data_b;
   logic        triggered, done;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference model: 0 idle, 1 armed, 2 counting, 3 done
   int     m_st = 0;
   int     m_ptr = 0;
   int     m_tp = 0;
   longint m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   capture_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cmd_arm(cmd_arm), .cmd_reset(cmd_reset),
      .smp_valid(smp_valid), .trig_in(trig_in), .delay_cfg(delay_cfg),
      .smp_a(smp_a), .smp_b(smp_b), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data_a(wr_data_a), .wr_data_b(wr_data_b), .cur_ptr(cur_ptr),
      .trig_ptr(trig_ptr), .triggered(triggered), .done(done)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit exp_we();
      return (m_st == 1 || m_st == 2) && smp_valid && !cmd_reset;
   endfunction

   task automatic compare_all();
      chk("R2", "wr_en", wr_en, exp_we());
      chk("R2", "wr_addr", wr_addr, cur_ptr);
      chk("R3", "cur_ptr", cur_ptr, m_ptr);
      chk("R5", "trig_ptr", trig_ptr, m_tp);
      chk("R5", "triggered", triggered, (m_st == 2 || m_st == 3));
      chk("R6", "done", done, m_st == 3);
      chk("R9", "wr_data_a", wr_data_a, {2'b00, smp_a[13:0]});
      chk("R9", "wr_data_b", wr_data_b, {2'b00, smp_b[13:0]});
   endtask

   // one clock: drive at the falling edge, compare, then advance the model
   task automatic cyc(input bit a, input bit r, input bit v, input bit t);
      bit we;
      cmd_arm = a; cmd_reset = r; smp_valid = v; trig_in = t;
      smp_a = 16'($urandom); smp_b = 16'($urandom);
      #1;
      compare_all();
      we = exp_we();
      @(posedge clk);
      if (r) begin
         m_st = 0; m_ptr = 0; m_tp = 0; m_cnt = 0;
      end else begin
         if (we) m_ptr = (m_ptr + 1) % DEPTH;
         if (a) m_st = 1;
         else if (m_st == 1 && t) begin
            m_tp = (we ? (m_ptr + DEPTH - 1) % DEPTH : m_ptr);
            m_cnt = longint'(delay_cfg);
            m_st = (delay_cfg == 0) ? 3 : 2;
         end else if (m_st == 2 && we) begin
            m_cnt--;
            if (m_cnt == 0) m_st = 3;
         end
      end
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      #1;
      // R1: reset state while rst_n is low
      chk("R1", "cur_ptr", cur_ptr, 0);
      chk("R1", "trig_ptr", trig_ptr, 0);
      chk("R1", "triggered", triggered, 0);
      chk("R1", "done", done, 0);
      chk("R1", "wr_en", wr_en, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4/R2: idle, strobes and triggers have no effect
      for (int i = 0; i < 6; i++) cyc(0, 0, 1, i[0]);

      // arm with trigger in the same cycle: R10
      delay_cfg = 32'd3;
      cyc(1, 0, 1, 1);
      for (int i = 0; i < 5; i++) cyc(0, 0, i[0], 0);
      // accepted trigger with write in same cycle: R5
      cyc(0, 0, 1, 1);
      // R6: three further writes with gaps; extra triggers ignored (R4)
      cyc(0, 0, 0, 1);
      cyc(0, 0, 1, 0);
      cyc(0, 0, 1, 1);
      cyc(0, 0, 0, 0);
      cyc(0, 0, 1, 0);
      // done: writes stop, triggers ignored
      for (int i = 0; i < 5; i++) cyc(0, 0, 1, i[0]);

      // R8: re-arm resumes from current pointer; zero delay
      delay_cfg = 32'd0;
      cyc(1, 0, 1, 0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0);
      cyc(0, 0, 0, 1);
      for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1);

      // R7: reset during counting, arm in the same cycle
      delay_cfg = 32'd100;
      cyc(1, 0, 1, 0);
      cyc(0, 0, 1, 1);
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0);
      cyc(1, 1, 1, 1);
      for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1);

      // R3: full wrap of the pointer, then a late trigger
      delay_cfg = 32'd5;
      cyc(1, 0, 0, 0);
      for (int i = 0; i < DEPTH + 10; i++) cyc(0, 0, 1, 0);
      cyc(0, 0, 1, 1);
      for (int i = 0; i < 9; i++) cyc(0, 0, 1, 0);

      // R1: asynchronous reset mid-capture and the first cycle after it
      cyc(1, 0, 1, 0);
      cyc(0, 0, 1, 0);
      rst_n = 1'b0;
      m_st = 0; m_ptr = 0; m_tp = 0; m_cnt = 0;
      #1;
      chk("R1", "cur_ptr async", cur_ptr, 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 0, 1, 1);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule